// File: doc/BRIEF.md
# Combinatorial PWM Signal Combiner

This block sits between a set of PWM generators and their output pins. It holds a bank of six logic cells, lettered A to F. Each cell picks two generator waveforms through 4-bit selectors and may invert either one. It then merges the pair with OR, AND or XOR. The merged signal can take over one output pin of a chosen generator. Cells A, C and E take over the high-side pin and cells B, D and F take over the low-side pin. Pins that no cell claims carry the generator's own output unchanged.

Software sets up each cell through one 32-bit word-aligned control register on a small memory-mapped port. A write lands on the next clock edge and is readable straight after. The combining path from the generator inputs to the pins has no registers, so the pins follow the waveforms within the same cycle. The generator count is a parameter. A selector that names a generator that is not built reads as logic 0, and a destination that is not built is left alone.

Top module: `pwm_comb_top`

## Requirements
- R1: After a synchronous reset, every cell's control register reads 0, and every pin follows its generator's own output.
- R2: A write with `bus_wr` high to byte address 0x1020 + 4·k (k = 0..5 for cells A..F) updates cell k at that clock edge. The read data (`bus_rdata`, combinational from `bus_addr`) then returns the cell's fields: source-1 selector in bits 15:12, source-2 selector in bits 11:8, source-1 invert in bit 7, source-2 invert in bit 6, function code in bits 5:4, destination in bits 2:0. Bits 31:16 and bit 3 always read 0.
- R3: A write to any other address changes no register, and so does a write to an address that is not word aligned. A read of such an address returns 0.
- R4: A source selector value s takes `gen_hi[s]` as its input. If s is not below NUM_GEN, that input is 0 before any inversion.
- R5: An invert bit of 1 complements its selected source before combining. A value of 0 passes the source unchanged.
- R6: Function code 00 gives the OR of the two conditioned sources, 01 gives the AND, and 10 gives the XOR.
- R7: Function code 11 makes the cell output a constant 0.
- R8: Cells A, C and E (k even) drive `pin_hi[d]` and cells B, D and F (k odd) drive `pin_lo[d]`, where d is the cell's destination field.
- R9: Destination 0 claims no pin. Neither does a destination that is not below NUM_GEN. Every unclaimed pin equals `gen_hi`/`gen_lo` of the same generator. Pins of generator 0 are never claimed.
- R10: When several cells claim the same pin, the cell with the lowest letter (lowest k) drives it.
- R11: A change on `gen_hi` or `gen_lo` reaches `pin_hi`/`pin_lo` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control registers |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address for register reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gen_hi | input | NUM_GEN | High-side outputs of the PWM generators; also the source pool for the selectors |
| gen_lo | input | NUM_GEN | Low-side outputs of the PWM generators |
| pin_hi | output | NUM_GEN | High-side pins after cell overrides |
| pin_lo | output | NUM_GEN | Low-side pins after cell overrides |

## Verification
The bench builds the block with NUM_GEN = 6. With that value, selector codes 6 to 15 fall on missing generators, so the forced-zero input can be reached from every cell. Destination codes 6 and 7 also point past the last generator, so the ignored-destination case gets exercised next to destination 0. Six generators still leave room for two cells of the same side to collide on one pin, which tests the lowest-letter priority on both the high and the low side.

// File: rtl/pwm_comb_pkg.sv
package pwm_comb_pkg;

    localparam int SEL_W  = 4;
    localparam int DEST_W = 3;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        FN_OR   = 2'b00,
        FN_AND  = 2'b01,
        FN_XOR  = 2'b10,
        FN_ZERO = 2'b11
    } comb_fn_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel_a;
        logic [SEL_W-1:0]  sel_b;
        logic              inv_a;
        logic              inv_b;
        comb_fn_e          fn;
        logic [DEST_W-1:0] dest;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    function automatic cell_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        cell_cfg_t c;
        c.sel_a = w[15:12];
        c.sel_b = w[11:8];
        c.inv_a = w[7];
        c.inv_b = w[6];
        c.fn    = comb_fn_e'(w[5:4]);
        c.dest  = w[2:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input cell_cfg_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[15:12] = c.sel_a;
        w[11:8]  = c.sel_b;
        w[7]     = c.inv_a;
        w[6]     = c.inv_b;
        w[5:4]   = c.fn;
        w[2:0]   = c.dest;
        return w;
    endfunction

    function automatic logic apply_fn(input comb_fn_e fn, input logic a, input logic b);
        logic r;
        unique case (fn)
            FN_OR:   r = a | b;
            FN_AND:  r = a & b;
            FN_XOR:  r = a ^ b;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_comb_regs.sv
module pwm_comb_regs
    import pwm_comb_pkg::*;
#(
    parameter int          NUM_CELLS = 6,
    parameter int          ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h1020
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic [WORD_W-1:0]            bus_wdata,
    output logic [WORD_W-1:0]            bus_rdata,
    output cell_cfg_t [NUM_CELLS-1:0]    cfg_o
);

    localparam int STRIDE = 4;

    logic [NUM_CELLS-1:0] hit;
    cell_cfg_t [NUM_CELLS-1:0] cfg_q;

    always_comb begin
        for (int k = 0; k < NUM_CELLS; k++) begin
            hit[k] = (bus_addr == ADDR_W'(BASE_ADDR + STRIDE * k));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            for (int k = 0; k < NUM_CELLS; k++) begin
                if (bus_wr && hit[k]) begin
                    cfg_q[k] <= word_to_cfg(bus_wdata);
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_CELLS; k++) begin
            if (hit[k]) begin
                bus_rdata = cfg_to_word(cfg_q[k]);
            end
        end
    end

    assign cfg_o = cfg_q;

    generate
        for (genvar k = 0; k < NUM_CELLS; k++) begin : g_chk
            assert_reset_clears_R1: assert property (@(posedge clk)
                rst |=> (cfg_q[k] == '0));

            assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
                (bus_wr && bus_addr == ADDR_W'(BASE_ADDR + STRIDE * k))
                |=> (cfg_q[k] == word_to_cfg($past(bus_wdata))));

            assert_other_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
                !(bus_wr && bus_addr == ADDR_W'(BASE_ADDR + STRIDE * k))
                |=> $stable(cfg_q[k]));
        end
    endgenerate

    assert_unused_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[31:16] == 16'h0) && !bus_rdata[3]);

endmodule

// File: rtl/pwm_comb_cell.sv
module pwm_comb_cell
    import pwm_comb_pkg::*;
#(
    parameter int NUM_GEN = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  cell_cfg_t          cfg_i,
    input  logic [NUM_GEN-1:0] src_i,
    output logic               out_o
);

    logic raw_a, raw_b;
    logic cond_a, cond_b;

    always_comb begin
        raw_a = 1'b0;
        raw_b = 1'b0;
        for (int i = 0; i < NUM_GEN; i++) begin
            if (int'(cfg_i.sel_a) == i) raw_a = src_i[i];
            if (int'(cfg_i.sel_b) == i) raw_b = src_i[i];
        end
    end

    assign cond_a = raw_a ^ cfg_i.inv_a;
    assign cond_b = raw_b ^ cfg_i.inv_b;
    assign out_o  = apply_fn(cfg_i.fn, cond_a, cond_b);

    assert_zero_code_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.fn == FN_ZERO) |-> !out_o);

    assert_absent_source_low_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg_i.sel_a) >= NUM_GEN && !cfg_i.inv_a && cfg_i.fn == FN_AND) |-> !out_o);

    assert_invert_both_or_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg_i.sel_a) >= NUM_GEN && cfg_i.inv_a && cfg_i.fn == FN_OR) |-> out_o);

endmodule

// File: rtl/pwm_comb_route.sv
module pwm_comb_route
    import pwm_comb_pkg::*;
#(
    parameter int NUM_GEN   = 8,
    parameter int NUM_CELLS = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  cell_cfg_t [NUM_CELLS-1:0] cfg_i,
    input  logic [NUM_CELLS-1:0]      cell_i,
    input  logic [NUM_GEN-1:0]        gen_hi,
    input  logic [NUM_GEN-1:0]        gen_lo,
    output logic [NUM_GEN-1:0]        pin_hi,
    output logic [NUM_GEN-1:0]        pin_lo
);

    always_comb begin
        pin_hi = gen_hi;
        pin_lo = gen_lo;
        // walk from the last cell down so the lowest letter is written last
        for (int c = NUM_CELLS - 1; c >= 0; c--) begin
            for (int g = 1; g < NUM_GEN; g++) begin
                if (int'(cfg_i[c].dest) == g) begin
                    if ((c % 2) == 0) pin_hi[g] = cell_i[c];
                    else              pin_lo[g] = cell_i[c];
                end
            end
        end
    end

    assert_gen0_untouched_R9: assert property (@(posedge clk) disable iff (rst)
        (pin_hi[0] == gen_hi[0]) && (pin_lo[0] == gen_lo[0]));

    generate
        if (NUM_CELLS > 2) begin : g_prio
            assert_first_cell_wins_R10: assert property (@(posedge clk) disable iff (rst)
                (cfg_i[0].dest != '0 && int'(cfg_i[0].dest) < NUM_GEN)
                |-> (pin_hi[cfg_i[0].dest] == cell_i[0]));
            assert_first_low_cell_wins_R8: assert property (@(posedge clk) disable iff (rst)
                (cfg_i[1].dest != '0 && int'(cfg_i[1].dest) < NUM_GEN)
                |-> (pin_lo[cfg_i[1].dest] == cell_i[1]));
        end
    endgenerate

endmodule

// File: rtl/pwm_comb_top.sv
module pwm_comb_top
    import pwm_comb_pkg::*;
#(
    parameter int          NUM_GEN   = 8,
    parameter int          NUM_CELLS = 6,
    parameter int          ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h1020
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_GEN-1:0] gen_hi,
    input  logic [NUM_GEN-1:0] gen_lo,
    output logic [NUM_GEN-1:0] pin_hi,
    output logic [NUM_GEN-1:0] pin_lo
);

    cell_cfg_t [NUM_CELLS-1:0] cfg;
    logic [NUM_CELLS-1:0]      cell_out;

    pwm_comb_regs #(
        .NUM_CELLS (NUM_CELLS),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg)
    );

    generate
        for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
            pwm_comb_cell #(
                .NUM_GEN (NUM_GEN)
            ) u_cell (
                .clk   (clk),
                .rst   (rst),
                .cfg_i (cfg[k]),
                .src_i (gen_hi),
                .out_o (cell_out[k])
            );
        end
    endgenerate

    pwm_comb_route #(
        .NUM_GEN   (NUM_GEN),
        .NUM_CELLS (NUM_CELLS)
    ) u_route (
        .clk    (clk),
        .rst    (rst),
        .cfg_i  (cfg),
        .cell_i (cell_out),
        .gen_hi (gen_hi),
        .gen_lo (gen_lo),
        .pin_hi (pin_hi),
        .pin_lo (pin_lo)
    );

endmodule

// File: tb/pwm_comb_top_bench.sv
module pwm_comb_top_bench;

    localparam int CLK_P = 10;
    localparam int NG    = 6;
    localparam int NC    = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   bus_addr = 16'h0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic [NG-1:0] gen_hi = '0;
    logic [NG-1:0] gen_lo = '0;
    logic [NG-1:0] pin_hi;
    logic [NG-1:0] pin_lo;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    reported = 1'b0;
    logic [31:0] mcfg [NC];

    always #(CLK_P/2) clk = ~clk;

    pwm_comb_top #(.NUM_GEN(NG), .NUM_CELLS(NC), .ADDR_W(16), .BASE_ADDR(32'h1020)) u_pwm_comb_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gen_hi(gen_hi), .gen_lo(gen_lo), .pin_hi(pin_hi), .pin_lo(pin_lo)
    );

    initial for (int k = 0; k < NC; k++) mcfg[k] = 32'h0;

    // behavioural model of the register bank
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            for (int k = 0; k < NC; k++) mcfg[k] <= 32'h0;
        end else if (bus_wr) begin
            for (int k = 0; k < NC; k++)
                if (int'(bus_addr) == 'h1020 + 4 * k) mcfg[k] <= bus_wdata & 32'h0000_FFF7;
        end
    end

    function automatic logic [31:0] exp_rdata();
        logic [31:0] r = 32'h0;
        for (int k = 0; k < NC; k++)
            if (int'(bus_addr) == 'h1020 + 4 * k) r = mcfg[k];
        return r;
    endfunction

    function automatic logic cell_val(input logic [31:0] w);
        int  sa = int'(w[15:12]);
        int  sb = int'(w[11:8]);
        logic a = (sa < NG) ? gen_hi[sa] : 1'b0;
        logic b = (sb < NG) ? gen_hi[sb] : 1'b0;
        a = a ^ w[7];
        b = b ^ w[6];
        case (w[5:4])
            2'b00:   return a | b;
            2'b01:   return a & b;
            2'b10:   return a ^ b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic exp_pins(output logic [NG-1:0] eh, output logic [NG-1:0] el);
        for (int g = 0; g < NG; g++) begin
            bit took_h = 0;
            bit took_l = 0;
            eh[g] = gen_hi[g];
            el[g] = gen_lo[g];
            for (int c = 0; c < NC; c++) begin
                if (g != 0 && int'(mcfg[c][2:0]) == g) begin
                    if (c % 2 == 0 && !took_h) begin eh[g] = cell_val(mcfg[c]); took_h = 1; end
                    if (c % 2 == 1 && !took_l) begin el[g] = cell_val(mcfg[c]); took_l = 1; end
                end
            end
        end
    endtask

    task automatic compare_all(input string tag);
        logic [NG-1:0] eh, el;
        logic [31:0] er;
        exp_pins(eh, el);
        er = exp_rdata();
        checks += 3;
        if (bus_rdata !== er) begin
            fails++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, bus_addr, bus_rdata, er);
        end
        if (pin_hi !== eh) begin
            fails++;
            $display("FAIL %s pin_hi actual=%b expected=%b", tag, pin_hi, eh);
        end
        if (pin_lo !== el) begin
            fails++;
            $display("FAIL %s pin_lo actual=%b expected=%b", tag, pin_lo, el);
        end
    endtask

    always @(negedge clk) if (started && !reported) compare_all(cur_req);

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [31:0] mk(input int sa, input int sb, input bit ia, input bit ib,
                                       input int fn, input int d);
        return {16'h0, 4'(sa), 4'(sb), ia, ib, 2'(fn), 1'b0, 3'(d)};
    endfunction

    task automatic wr(input int addr, input logic [31:0] data);
        @(posedge clk); #1;
        bus_addr = 16'(addr); bus_wdata = data; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr);
        @(posedge clk); #1;
        bus_addr = 16'(addr);
        @(posedge clk);
    endtask

    task automatic gens(input logic [NG-1:0] h, input logic [NG-1:0] l);
        @(posedge clk); #1;
        gen_hi = h; gen_lo = l;
    endtask

    task automatic rgens(input int n);
        for (int i = 0; i < n; i++) gens(NG'($urandom), NG'($urandom));
    endtask

    task automatic clear_all();
        for (int k = 0; k < NC; k++) wr('h1020 + 4 * k, 32'h0);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired in %s actual=running expected=done", cur_req);
        report();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int k = 0; k < NC; k++) begin
            rd('h1020 + 4 * k);
            gens(NG'($urandom), NG'($urandom));
        end

        // R2: writes land and read back with unused bits zero
        cur_req = "R2";
        wr('h1020, 32'hFFFF_FFFF);
        rd('h1020);
        for (int k = 1; k < NC; k++) wr('h1020 + 4 * k, $urandom);
        for (int k = 0; k < NC; k++) rd('h1020 + 4 * k);

        // R3: foreign and misaligned addresses
        cur_req = "R3";
        wr('h1038, 32'h0000_FFFF);
        wr('h1021, 32'h0000_1234);
        wr('h1026, 32'h0000_5678);
        wr('h101C, 32'h0000_FFFF);
        wr('h0020, 32'h0000_FFFF);
        rd('h1038); rd('h1021); rd('h101C);
        for (int k = 0; k < NC; k++) rd('h1020 + 4 * k);

        // R4: selector reach and absent sources
        cur_req = "R4";
        clear_all();
        for (int s = 0; s < 16; s++) begin
            wr('h1020, mk(s, 15, 0, 0, 0, 1));
            wr('h1024, mk(s, 0, 0, 0, 1, 1));
            gens(NG'(1 << (s % NG)), '0);
            rgens(3);
        end

        // R5: polarity
        cur_req = "R5";
        for (int p = 0; p < 4; p++) begin
            wr('h1020, mk(2, 3, p[0], p[1], 1, 2));
            wr('h1024, mk(4, 9, p[1], p[0], 0, 2));
            rgens(4);
        end

        // R6: the three functions
        cur_req = "R6";
        for (int f = 0; f < 3; f++) begin
            wr('h1020, mk(1, 2, 0, 0, f, 3));
            wr('h1028, mk(3, 5, 0, 1, f, 4));
            wr('h102C, mk(0, 4, 1, 0, f, 5));
            for (int v = 0; v < 4; v++) gens(NG'({v[1], v[0], v[1], v[0], v[1], v[0]}), NG'($urandom));
            rgens(4);
        end

        // R7: reserved code gives zero
        cur_req = "R7";
        wr('h1020, mk(1, 2, 1, 1, 3, 1));
        wr('h1024, mk(15, 15, 1, 1, 3, 1));
        gens('1, '1);
        rgens(4);

        // R8: side selection per cell letter
        cur_req = "R8";
        clear_all();
        wr('h1024, mk(1, 1, 1, 0, 0, 2));
        wr('h102C, mk(2, 2, 1, 0, 0, 3));
        wr('h1034, mk(3, 3, 1, 0, 0, 4));
        wr('h1030, mk(4, 4, 1, 0, 0, 5));
        rgens(6);

        // R9: no-override destinations
        cur_req = "R9";
        clear_all();
        wr('h1020, mk(1, 2, 1, 1, 0, 0));
        wr('h1024, mk(1, 2, 1, 1, 0, 6));
        wr('h1028, mk(1, 2, 1, 1, 0, 7));
        wr('h102C, mk(1, 2, 1, 1, 0, 7));
        rgens(6);

        // R10: collisions on one pin
        cur_req = "R10";
        wr('h1020, mk(1, 2, 0, 0, 2, 2));
        wr('h1028, mk(1, 2, 1, 0, 2, 2));
        wr('h1030, mk(3, 3, 0, 1, 0, 2));
        wr('h1024, mk(4, 5, 0, 0, 0, 3));
        wr('h102C, mk(4, 5, 1, 1, 1, 3));
        wr('h1034, mk(0, 0, 1, 1, 0, 3));
        rgens(8);
        wr('h1020, mk(1, 2, 0, 0, 2, 5));
        rgens(4);

        // R11: combinational path between clock edges
        cur_req = "R11";
        for (int i = 0; i < 8; i++) begin
            logic [NG-1:0] eh, el;
            @(negedge clk); #1;
            gen_hi = NG'($urandom); gen_lo = NG'($urandom);
            #1;
            exp_pins(eh, el);
            checks++;
            if (pin_hi !== eh || pin_lo !== el) begin
                fails++;
                $display("FAIL R11 pins actual=%b/%b expected=%b/%b", pin_hi, pin_lo, eh, el);
            end
        end

        // mixed random traffic
        cur_req = "R6";
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 2) == 0) wr('h1020 + 4 * $urandom_range(0, NC - 1), $urandom);
            else gens(NG'($urandom), NG'($urandom));
        end

        // reset again mid-run
        cur_req = "R1";
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        for (int k = 0; k < NC; k++) rd('h1020 + 4 * k);

        @(negedge clk); #1;
        report();
    end

endmodule